// File: doc/BRIEF.md
# Dual-Buffer Ethernet Receive Controller

This block takes frames arriving as a byte stream and lands them in one of two memory-mapped frame buffers, called ping and pong, that a host reads over a simple word bus. Each buffer ends in a status word. Its `done` flag is the ownership token: the hardware sets it once a whole frame sits in the buffer. The host clears it after consuming the frame, which hands the buffer back.

The hardware fills the buffers in strict alternation, so software always finds the next frame in the buffer after the one it last released. A frame that arrives while the buffer due next is still owned by the host is thrown away, and a saturating drop counter records it. A frame that does not fit is cut short and never published. A frame whose accept input is low on its last byte is never published either. The pong buffer can be removed at build time, and then every frame goes to ping. FCS bytes are stored like any other data. Address filtering is reduced to the accept input.

Top module: `dual_rx_buffer`

## Requirements
- R1: After reset, both status words read 0, `irq` is 0, `drop_cnt` is 0, and the first frame goes to ping.
- R2: Byte n of a stored frame lands at byte offset n of its buffer, in word n/4 and bits [8*(n%4)+7 : 8*(n%4)], little-endian. Ping starts at byte address 2*BUF_BYTES and pong at 3*BUF_BYTES. A read returns its data on `bus_rdata` in the cycle after `bus_rd`. Addresses below 2*BUF_BYTES read as zero.
- R3: Each buffer's status word sits at its base + BUF_BYTES - 4, with bit 0 = done and bit 3 = interrupt enable. Done becomes 1 in the cycle after the last byte of a frame that was stored whole and had `rx_accept` high on its last byte.
- R4: With the pong buffer present, stored frames go ping, pong, ping, and so on. The expected buffer changes only when a frame is published.
- R5: If the expected buffer's done is 1 when a frame's first byte arrives, the whole frame is discarded. Buffer contents and the expected buffer stay unchanged, and `drop_cnt` rises by 1, saturating at its maximum.
- R6: A host write to a status word clears done when bit 0 is 0 and leaves it unchanged when bit 0 is 1. Such a write also loads the interrupt enable from bit 3, so writing 0x8 alone flushes the buffer and enables its interrupt.
- R7: `irq` is 1 exactly when some buffer has both done and interrupt enable at 1.
- R8: A frame longer than BUF_BYTES - 4 bytes has its first BUF_BYTES - 4 bytes stored. It is not marked done, it does not move the expected buffer, and it is not counted as a drop.
- R9: A frame with `rx_accept` low on its last byte is not marked done, does not move the expected buffer, and is not counted as a drop.
- R10: With PONG_EN = 0, every frame goes to ping. The pong region, its status word included, reads as zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A frame byte is present this cycle |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | This byte ends the frame |
| rx_accept | input | 1 | Keep the frame; sampled with the last byte |
| bus_addr | input | ADDR_W | Host byte address, word aligned |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 32 | Host write data |
| bus_rd | input | 1 | Host read strobe |
| bus_rdata | output | 32 | Host read data, one cycle after `bus_rd` |
| irq | output | 1 | Receive interrupt |
| drop_cnt | output | DROP_W | Saturating count of discarded frames |

## Verification
The bench builds two copies side by side from the same stimulus. Both use BUF_BYTES = 256, so a frame of a few hundred bytes runs past the end of a buffer and the truncation path is reached in a few hundred cycles. Both use DROP_W = 3, so ten back-to-back discards drive the counter into saturation. One copy has PONG_EN = 1 and the other PONG_EN = 0, so the same frames show alternation in the first and single-buffer discards in the second.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  typedef enum logic [1:0] {
    FILL_IDLE,
    FILL_STORE,
    FILL_SKIP
  } fill_state_e;

  typedef enum logic [1:0] {
    SRC_ZERO,
    SRC_DATA,
    SRC_STAT
  } rd_src_e;

  localparam int unsigned DONE_BIT = 0;
  localparam int unsigned IE_BIT   = 3;

  function automatic logic [31:0] stat_word(input logic done, input logic ie);
    logic [31:0] w;
    w           = '0;
    w[DONE_BIT] = done;
    w[IE_BIT]   = ie;
    return w;
  endfunction

endpackage

// File: rtl/rxb_bank.sv
module rxb_bank #(
  parameter int unsigned WORDS  = 512,
  parameter int unsigned WIDX_W = 9
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_word,
  input  logic [1:0]        wr_lane,
  input  logic [7:0]        wr_byte,
  input  logic              rd_en,
  input  logic [WIDX_W-1:0] rd_word,
  output logic [31:0]       rd_data
);

  logic [3:0][7:0] mem [WORDS];
  logic [31:0]     rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_word][wr_lane] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_word];
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/rxb_fill.sv
module rxb_fill
  import rxb_pkg::*;
#(
  parameter int unsigned NBUF       = 2,
  parameter int unsigned DATA_BYTES = 2044,
  parameter int unsigned CNT_W      = 11,
  parameter int unsigned DROP_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic              rx_accept,
  input  logic [NBUF-1:0]   done_q,
  output logic              wr_en,
  output logic              wr_buf,
  output logic [CNT_W-1:0]  wr_addr,
  output logic [NBUF-1:0]   set_done,
  output logic              ptr_q,
  output logic [DROP_W-1:0] drop_q
);

  localparam bit                TOGGLE   = (NBUF > 1);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  fill_state_e       st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ovf_q, ovf_d;
  logic              tgt_q, tgt_d;
  logic              ptr_d;
  logic [DROP_W-1:0] drop_d;

  logic             start, full_now, tgt_now, storing, fits, ovf_any, finish_ok;
  logic [CNT_W-1:0] idx;
  logic             ptr_en, drop_en;

  always_comb begin
    start    = rx_valid && (st_q == FILL_IDLE);
    full_now = 1'b0;
    for (int i = 0; i < NBUF; i++) begin
      if (ptr_q == 1'(i)) full_now = done_q[i];
    end
    tgt_now   = start ? ptr_q : tgt_q;
    storing   = rx_valid && (start ? !full_now : (st_q == FILL_STORE));
    idx       = start ? '0 : cnt_q;
    fits      = (idx < CNT_W'(DATA_BYTES));
    ovf_any   = (!start && ovf_q) || !fits;
    finish_ok = storing && rx_last && rx_accept && !ovf_any;

    wr_en   = storing && fits;
    wr_buf  = tgt_now;
    wr_addr = idx;
    for (int i = 0; i < NBUF; i++) begin
      set_done[i] = finish_ok && (tgt_now == 1'(i));
    end

    st_d = st_q;
    if (rx_last)    st_d = FILL_IDLE;
    else if (start) st_d = full_now ? FILL_SKIP : FILL_STORE;
    cnt_d = fits ? idx + 1'b1 : idx;
    ovf_d = ovf_any;
    tgt_d = tgt_now;

    ptr_en  = finish_ok && TOGGLE;
    ptr_d   = ~ptr_q;
    drop_en = start && full_now && (drop_q != DROP_MAX);
    drop_d  = drop_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FILL_IDLE;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      tgt_q <= 1'b0;
    end else if (rx_valid) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      tgt_q <= tgt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= 1'b0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       drop_q <= '0;
    else if (drop_en) drop_q <= drop_d;
  end

endmodule

// File: rtl/rxb_status.sv
module rxb_status #(
  parameter int unsigned NBUF = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBUF-1:0] set_done,
  input  logic [NBUF-1:0] host_we,
  input  logic            wr_done,
  input  logic            wr_ie,
  output logic [NBUF-1:0] done_q,
  output logic [NBUF-1:0] ie_q,
  output logic            irq
);

  logic [NBUF-1:0] done_d, done_en;

  always_comb begin
    for (int i = 0; i < NBUF; i++) begin
      done_en[i] = set_done[i] || host_we[i];
      done_d[i]  = set_done[i] || (done_q[i] && wr_done);
    end
  end

  for (genvar g = 0; g < NBUF; g++) begin : g_stat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          done_q[g] <= 1'b0;
      else if (done_en[g]) done_q[g] <= done_d[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ie_q[g] <= 1'b0;
      else if (host_we[g]) ie_q[g] <= wr_ie;
    end
  end

  assign irq = |(done_q & ie_q);

endmodule

// File: rtl/dual_rx_buffer.sv
module dual_rx_buffer
  import rxb_pkg::*;
#(
  parameter  int unsigned BUF_BYTES = 2048,
  parameter  bit          PONG_EN   = 1'b1,
  parameter  int unsigned DROP_W    = 16,
  localparam int unsigned ADDR_W    = $clog2(BUF_BYTES) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_accept,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [DROP_W-1:0] drop_cnt
);

  localparam int unsigned NBUF       = PONG_EN ? 2 : 1;
  localparam int unsigned WORDS      = BUF_BYTES / 4;
  localparam int unsigned WIDX_W     = $clog2(WORDS);
  localparam int unsigned DATA_BYTES = BUF_BYTES - 4;
  localparam int unsigned CNT_W      = $clog2(BUF_BYTES);
  localparam logic [WIDX_W-1:0] STAT_IDX = WIDX_W'(WORDS - 1);

  logic              fill_wr_en, fill_buf;
  logic [CNT_W-1:0]  fill_addr;
  logic [NBUF-1:0]   set_done, host_we, done_q, ie_q;
  logic              ptr_q;

  logic              in_rx, buf_sel, is_stat, buf_ok;
  logic [WIDX_W-1:0] word_idx;
  logic [NBUF-1:0]   bank_rd_en;
  logic [31:0]       bank_rd [NBUF];
  logic [31:0]       stat_sel;

  rd_src_e     src_q, src_d;
  logic        rbuf_q;
  logic [31:0] stat_q;

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:4], bus_wdata[2:1]};

  always_comb begin
    in_rx    = bus_addr[ADDR_W-1];
    buf_sel  = bus_addr[ADDR_W-2];
    word_idx = bus_addr[ADDR_W-3:2];
    is_stat  = (word_idx == STAT_IDX);
    buf_ok   = in_rx && ((NBUF > 1) || !buf_sel);
    stat_sel = '0;
    for (int i = 0; i < NBUF; i++) begin
      host_we[i]    = bus_wr && buf_ok && is_stat && (buf_sel == 1'(i));
      bank_rd_en[i] = bus_rd && buf_ok && !is_stat && (buf_sel == 1'(i));
      if (buf_sel == 1'(i)) stat_sel = stat_word(done_q[i], ie_q[i]);
    end
    if (!buf_ok)      src_d = SRC_ZERO;
    else if (is_stat) src_d = SRC_STAT;
    else              src_d = SRC_DATA;
  end

  rxb_fill #(
    .NBUF      (NBUF),
    .DATA_BYTES(DATA_BYTES),
    .CNT_W     (CNT_W),
    .DROP_W    (DROP_W)
  ) u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_last  (rx_last),
    .rx_accept(rx_accept),
    .done_q   (done_q),
    .wr_en    (fill_wr_en),
    .wr_buf   (fill_buf),
    .wr_addr  (fill_addr),
    .set_done (set_done),
    .ptr_q    (ptr_q),
    .drop_q   (drop_cnt)
  );

  rxb_status #(
    .NBUF(NBUF)
  ) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_done(set_done),
    .host_we (host_we),
    .wr_done (bus_wdata[DONE_BIT]),
    .wr_ie   (bus_wdata[IE_BIT]),
    .done_q  (done_q),
    .ie_q    (ie_q),
    .irq     (irq)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_bank
    rxb_bank #(
      .WORDS (WORDS),
      .WIDX_W(WIDX_W)
    ) u_bank (
      .clk    (clk),
      .wr_en  (fill_wr_en && (fill_buf == 1'(g))),
      .wr_word(fill_addr[CNT_W-1:2]),
      .wr_lane(fill_addr[1:0]),
      .wr_byte(rx_data),
      .rd_en  (bank_rd_en[g]),
      .rd_word(word_idx),
      .rd_data(bank_rd[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_ZERO;
      rbuf_q <= 1'b0;
      stat_q <= '0;
    end else if (bus_rd) begin
      src_q  <= src_d;
      rbuf_q <= buf_sel;
      stat_q <= stat_sel;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (src_q == SRC_STAT) bus_rdata = stat_q;
    else if (src_q == SRC_DATA) begin
      for (int i = 0; i < NBUF; i++) begin
        if (rbuf_q == 1'(i)) bus_rdata = bank_rd[i];
      end
    end
  end

endmodule

// File: rtl/dual_rx_buffer_chk.sv
module dual_rx_buffer_chk #(
  parameter int unsigned NBUF   = 2,
  parameter int unsigned DROP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_last,
  input logic              rx_accept,
  input logic              irq,
  input logic [DROP_W-1:0] drop_cnt,
  input logic [NBUF-1:0]   done_q,
  input logic [NBUF-1:0]   ie_q,
  input logic              ptr_q
);

  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  // R3
  done_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_q & ~$past(done_q)) != '0) |-> $past(rx_valid && rx_last && rx_accept));

  // R4
  one_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_q & ~$past(done_q)));

  // R4
  ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q != $past(ptr_q)) |-> ((done_q & ~$past(done_q)) != '0));

  // R5
  drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt != $past(drop_cnt)) |-> ((drop_cnt == $past(drop_cnt) + 1'b1) && $past(rx_valid)));

  // R5
  drop_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt == DROP_MAX) |=> (drop_cnt == DROP_MAX));

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((done_q & ie_q) != '0));

endmodule

bind dual_rx_buffer dual_rx_buffer_chk #(
  .NBUF  (NBUF),
  .DROP_W(DROP_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_valid (rx_valid),
  .rx_last  (rx_last),
  .rx_accept(rx_accept),
  .irq      (irq),
  .drop_cnt (drop_cnt),
  .done_q   (done_q),
  .ie_q     (ie_q),
  .ptr_q    (ptr_q)
);

// File: tb/dual_rx_buffer_test.sv
module dual_rx_buffer_test;

  localparam int CLK_PERIOD = 10;
  localparam int BUF  = 256;
  localparam int DATA = BUF - 4;
  localparam int AW   = 10;
  localparam int DW   = 3;
  localparam int DMAX = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 1'b0, rx_last = 1'b0, rx_accept = 1'b0;
  logic [7:0]    rx_data = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   rdata_d, rdata_s;
  logic          irq_d, irq_s;
  logic [DW-1:0] drop_d, drop_s;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int  m_done [2][2];
  int  m_ie   [2][2];
  int  m_ptr  [2];
  int  m_drop [2];
  byte m_mem  [2][2][BUF];
  bit  m_wr   [2][2][BUF];
  byte frm    [320];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_rx_buffer #(.BUF_BYTES(BUF), .PONG_EN(1'b1), .DROP_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_accept(rx_accept), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(rdata_d), .irq(irq_d), .drop_cnt(drop_d));

  dual_rx_buffer #(.BUF_BYTES(BUF), .PONG_EN(1'b0), .DROP_W(DW)) uut_single (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_accept(rx_accept), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(rdata_s), .irq(irq_s), .drop_cnt(drop_s));

  function automatic int nbuf(int k);
    return (k == 0) ? 2 : 1;
  endfunction

  function automatic int base_of(int b);
    return 2 * BUF + b * BUF;
  endfunction

  function automatic logic [31:0] exp_stat(int k, int b);
    logic [31:0] v = '0;
    if (b < nbuf(k)) begin
      v[0] = (m_done[k][b] != 0);
      v[3] = (m_ie[k][b] != 0);
    end
    return v;
  endfunction

  function automatic logic exp_irq(int k);
    logic r = 1'b0;
    for (int b = 0; b < nbuf(k); b++)
      if (m_done[k][b] != 0 && m_ie[k][b] != 0) r = 1'b1;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_read(input int a, output logic [31:0] r0, output logic [31:0] r1);
    @(negedge clk);
    bus_addr = AW'(a);
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    r0 = rdata_d;
    r1 = rdata_s;
  endtask

  task automatic host_stat(input int b, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = AW'(base_of(b) + BUF - 4);
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    for (int k = 0; k < 2; k++) begin
      if (b < nbuf(k)) begin
        if (!d[0]) m_done[k][b] = 0;
        m_ie[k][b] = int'(d[3]);
      end
    end
  endtask

  task automatic send_frame(input int len, input bit acc);
    for (int i = 0; i < len; i++) frm[i] = byte'($urandom);
    for (int k = 0; k < 2; k++) begin
      int b = m_ptr[k];
      if (m_done[k][b] != 0) begin
        if (m_drop[k] < DMAX) m_drop[k]++;
      end else begin
        for (int i = 0; i < len && i < DATA; i++) begin
          m_mem[k][b][i] = frm[i];
          m_wr[k][b][i]  = 1'b1;
        end
        if (acc && len <= DATA) begin
          m_done[k][b] = 1;
          if (nbuf(k) == 2) m_ptr[k] = 1 - b;
        end
      end
    end
    for (int i = 0; i < len; i++) begin
      if (($urandom % 5) == 0) begin
        @(negedge clk);
        rx_valid = 1'b0;
      end
      @(negedge clk);
      rx_valid  = 1'b1;
      rx_data   = frm[i];
      rx_last   = (i == len - 1);
      rx_accept = acc;
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last  = 1'b0;
  endtask

  task automatic check_ports(input string req);
    chk(drop_d == DW'(m_drop[0]), req, "drop_cnt dual", longint'(drop_d), longint'(m_drop[0]));
    chk(drop_s == DW'(m_drop[1]), req, "drop_cnt single", longint'(drop_s), longint'(m_drop[1]));
    chk(irq_d == exp_irq(0), req, "irq dual", longint'(irq_d), longint'(exp_irq(0)));
    chk(irq_s == exp_irq(1), req, "irq single", longint'(irq_s), longint'(exp_irq(1)));
  endtask

  task automatic check_status(input string req);
    logic [31:0] r0, r1;
    for (int b = 0; b < 2; b++) begin
      bus_read(base_of(b) + BUF - 4, r0, r1);
      chk(r0 == exp_stat(0, b), req, "status dual", longint'(r0), longint'(exp_stat(0, b)));
      chk(r1 == exp_stat(1, b), req, "status single", longint'(r1), longint'(exp_stat(1, b)));
    end
  endtask

  task automatic check_word(input string req, input int b, input int w);
    logic [31:0] r [2];
    logic [31:0] e, m;
    bus_read(base_of(b) + 4 * w, r[0], r[1]);
    for (int k = 0; k < 2; k++) begin
      e = '0;
      m = '0;
      if (b < nbuf(k)) begin
        for (int l = 0; l < 4; l++) begin
          if (m_wr[k][b][4*w+l]) begin
            e[8*l +: 8] = m_mem[k][b][4*w+l];
            m[8*l +: 8] = 8'hFF;
          end
        end
      end else begin
        m = '1;
      end
      chk((r[k] & m) == e, req, (k == 0) ? "data dual" : "data single",
          longint'(r[k] & m), longint'(e));
    end
  endtask

  task automatic check_words(input string req, input int b, input int nw);
    for (int w = 0; w < nw; w++) check_word(req, b, w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r0, r1;
    void'($urandom(32'd7331));
    for (int k = 0; k < 2; k++) begin
      m_ptr[k] = 0;
      m_drop[k] = 0;
      for (int b = 0; b < 2; b++) begin
        m_done[k][b] = 0;
        m_ie[k][b] = 0;
        for (int i = 0; i < BUF; i++) begin
          m_mem[k][b][i] = 0;
          m_wr[k][b][i] = 1'b0;
        end
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check_ports("R1");
    check_status("R1");

    // R2 R3: first frame lands in ping on both copies
    send_frame(10, 1'b1);
    check_ports("R3");
    check_status("R3");
    check_words("R2", 0, 3);

    // R4 R10: dual copy moves to pong, single copy drops
    send_frame(7, 1'b1);
    check_ports("R10");
    check_status("R4");
    check_words("R4", 1, 2);
    check_words("R10", 0, 3);

    // R5: expected buffer still owned, frame discarded, contents intact
    send_frame(12, 1'b1);
    check_ports("R5");
    check_words("R5", 0, 3);

    // R6 R7: enable interrupt without clearing, then flush
    host_stat(0, 32'h9);
    check_ports("R7");
    check_status("R6");
    host_stat(0, 32'h8);
    check_ports("R7");
    check_status("R6");

    // R4: dual copy returns to ping after pong
    send_frame(9, 1'b1);
    check_status("R4");
    check_words("R4", 0, 3);
    check_ports("R7");

    // R6: writing bit 0 = 1 to a cleared status does not set done
    host_stat(1, 32'h0);
    host_stat(1, 32'h1);
    check_status("R6");
    host_stat(0, 32'h0);

    // R9: frame without accept is not published
    send_frame(20, 1'b0);
    check_ports("R9");
    check_status("R9");

    // R8: oversize frame truncated, not published, not a drop
    send_frame(DATA + 8, 1'b1);
    check_ports("R8");
    check_status("R8");
    check_word("R8", m_ptr[0], DATA / 4 - 1);
    send_frame(5, 1'b1);
    check_status("R8");
    check_words("R8", 0, 2);

    // R2 R10: unmapped low address and pong region in single copy read zero
    bus_read(4, r0, r1);
    chk(r0 == 0, "R2", "low region dual", longint'(r0), 0);
    chk(r1 == 0, "R2", "low region single", longint'(r1), 0);
    host_stat(1, 32'h8);
    check_status("R10");
    check_word("R10", 1, 0);

    // R5: saturation of the drop counter
    for (int n = 0; n < 12; n++) send_frame(3, 1'b1);
    check_ports("R5");

    // random phase
    for (int it = 0; it < 60; it++) begin
      int len;
      for (int b = 0; b < 2; b++) begin
        if (($urandom % 2) == 0) host_stat(b, {28'b0, 1'($urandom), 3'b000});
      end
      len = ((($urandom % 8) == 0) ? (DATA - 4 + int'($urandom % 12))
                                   : (1 + int'($urandom % 80)));
      send_frame(len, (($urandom % 8) != 0));
      check_ports("R4");
      check_status("R3");
      check_word("R2", int'($urandom % 2), int'($urandom % 20));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule